// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

The walker scans a ring of transmit descriptors held in system memory and assembles one outgoing frame from one or more chained buffers. Each descriptor is four 32-bit words. The walker reads a descriptor's control word, then its buffer-address word. For every buffer it hands an address and byte count to a separate data mover. It then returns the descriptors to software by clearing their ownership bit, and signals a completed frame with a one-cycle pulse.

A scan starts on a demand pulse or on a free-running poll timer. It processes up to a fixed number of frames and ends early when the next descriptor is still owned by software. A chain that runs out of owned descriptors before its last buffer raises an underflow pulse, and the frame is abandoned. The descriptor memory is reached through a word-addressed read/write master with a request/acknowledge handshake. The data mover uses a second request/acknowledge pair.

Top module: `txring_walker`

## Requirements
- R1: No memory request is issued unless `run_i` is high, `ring_base_i` is nonzero and `layout_i` is 2 or 3. While `run_i` is low, any scan in progress is abandoned within one cycle.
- R2: Descriptor n starts at byte address ring_base + 16·n, and the control word is at byte offset 4. With layout 2 the buffer address is at byte offset 0. With layout 3 it is at byte offset 8.
- R3: In the control word, bit 31 is the ownership bit, bit 29 is the checksum-append bit, bit 25 is start-of-frame and bit 24 is end-of-frame. Bits 11..0 hold the buffer size as a negative two's-complement value, so the byte count is (−field) mod 4096. A buffer whose count is 0 produces no data mover request.
- R4: Each buffer with a nonzero count gives one data mover request carrying the buffer address and the byte count. The request, and every memory request, stays stable until acknowledged.
- R5: A descriptor without start-of-frame has its control word written back with only the ownership bit cleared, right after its buffer is handled. A start-of-frame descriptor is not written before the frame completes.
- R6: After the end-of-frame buffer, the first descriptor's control word is written back with only the ownership bit cleared. Then `frame_done_o` pulses for one cycle.
- R7: If a following descriptor in a chain is not owned, `underflow_o` pulses once and the scan stops. There is no done pulse, and the first descriptor keeps its ownership bit.
- R8: The position advances once per consumed descriptor and wraps to 0 at `ring_len_i`. It returns to 0 while `run_i` is low.
- R9: One scan completes at most 16 frames. It ends without any pulse when the next frame's first descriptor is not owned.
- R10: The byte counts requested for one frame never total more than 2048. A count that would pass that total is cut down, and a count cut to 0 is skipped.
- R11: A scan starts on `demand_i` or once every POLL_CYCLES cycles of `run_i` high, with the poll timer held at 0 while `run_i` is low. A trigger that arrives during a scan starts one more scan after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Transmit enable |
| demand_i | input | 1 | Scan request pulse |
| ring_base_i | input | 32 | Ring byte address, 16-byte aligned |
| ring_len_i | input | 10 | Number of descriptors in the ring |
| layout_i | input | 2 | Descriptor layout select (2 or 3) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 30 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| dm_req_o | output | 1 | Data mover request |
| dm_addr_o | output | 32 | Buffer byte address |
| dm_len_o | output | 12 | Buffer byte count |
| dm_ack_i | input | 1 | Data mover acknowledge |
| frame_done_o | output | 1 | Frame completed pulse |
| underflow_o | output | 1 | Chain underflow pulse |

## Verification
The handshake-hold properties assume that an acknowledge only answers a pending request and that `run_i` does not fall in the middle of a handshake. They also assume that ring base, ring length and layout do not change while a scan is running. The bench respects all three by changing configuration and descriptor memory only while `run_i` is low, and by modelling both responders so that they acknowledge a standing request exactly once. Random frames with one to three buffers, random sizes including zero, and both layouts are mixed with directed cases: underflow, the 2048-byte cut, the 16-frame limit with ring wrap, a re-trigger during a scan, and the poll start.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int OWN_BIT  = 31;
  localparam int FCS_BIT  = 29;
  localparam int STP_BIT  = 25;
  localparam int ENP_BIT  = 24;
  localparam int LEN_W    = 12;
  localparam logic [1:0] LAY_STD  = 2'd2;
  localparam logic [1:0] LAY_SWAP = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CTL, ST_RD_BUF, ST_MOVE, ST_WB_MID, ST_ADV, ST_WB_FIRST
  } txw_state_e;
endpackage

// File: rtl/txw_ring_ptr.sv
module txw_ring_ptr #(
  parameter int POS_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic [POS_W:0]   ring_len_i,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W:0] inc;
  assign inc = {1'b0, pos_o} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_o <= '0;
    else if (clear_i)  pos_o <= '0;
    else if (adv_i)    pos_o <= (inc >= ring_len_i) ? '0 : inc[POS_W-1:0];
  end

  assert_pos_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clear_i) |=> (pos_o == '0 || pos_o == $past(pos_o) + 1'b1));
endmodule

// File: rtl/txw_len_calc.sv
module txw_len_calc #(
  parameter int LEN_W     = 12,
  parameter int TOT_W     = 12,
  parameter int MAX_FRAME = 2048
) (
  input  logic [LEN_W-1:0] field_i,
  input  logic [TOT_W-1:0] total_i,
  output logic [LEN_W-1:0] count_o
);
  localparam int CW = ((LEN_W > TOT_W) ? LEN_W : TOT_W) + 1;

  logic [LEN_W-1:0] raw;
  logic [CW-1:0]    raw_e, room_e;

  always_comb begin
    raw     = LEN_W'(~field_i + 1'b1);
    raw_e   = CW'(raw);
    room_e  = CW'(MAX_FRAME) - CW'(total_i);
    count_o = (raw_e > room_e) ? LEN_W'(room_e) : raw;
  end
endmodule

// File: rtl/txw_ctrl.sv
module txw_ctrl
  import txw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int POS_W       = 9,
  parameter int TOT_W       = 12,
  parameter int MAX_FRAME   = 2048,
  parameter int MAX_FRAMES  = 16,
  parameter int POLL_CYCLES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              demand_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        layout_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic              adv_o,
  input  logic [LEN_W-1:0]  count_i,
  output logic [LEN_W-1:0]  field_o,
  output logic [TOT_W-1:0]  total_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-3:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              dm_req_o,
  output logic [31:0]       dm_addr_o,
  output logic [LEN_W-1:0]  dm_len_o,
  input  logic              dm_ack_i,
  output logic              frame_done_o,
  output logic              underflow_o
);
  localparam int WA_W = ADDR_W - 2;
  localparam int FR_W = $clog2(MAX_FRAMES + 1);

  txw_state_e       state_q;
  logic [31:0]      ctl_q, first_ctl_q;
  logic [POS_W-1:0] first_pos_q, pos_sel;
  logic             first_q, pend_q, poll_tick;
  logic [1:0]       lay_q;
  logic [FR_W-1:0]  frames_q;
  logic [TOT_W-1:0] total_q;
  logic [WA_W-1:0]  word_off;
  logic             start_ok;

  // poll timer, variant picked by parameter
  generate
    if (POLL_CYCLES > 0) begin : g_poll
      localparam int PW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
      logic [PW-1:0] poll_q;
      assign poll_tick = run_i && (poll_q == PW'(POLL_CYCLES - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        poll_q <= '0;
        else if (!run_i)    poll_q <= '0;
        else if (poll_tick) poll_q <= '0;
        else                poll_q <= poll_q + 1'b1;
      end
    end else begin : g_nopoll
      assign poll_tick = 1'b0;
    end
  endgenerate

  assign start_ok = pend_q && run_i && (base_i != '0) &&
                    (layout_i == LAY_STD || layout_i == LAY_SWAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= 1'b0;
    else if (state_q == ST_IDLE) pend_q <= demand_i || poll_tick;
    else                        pend_q <= pend_q || demand_i || poll_tick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      ctl_q        <= '0;
      first_ctl_q  <= '0;
      first_pos_q  <= '0;
      first_q      <= 1'b0;
      lay_q        <= LAY_STD;
      frames_q     <= '0;
      total_q      <= '0;
      dm_addr_o    <= '0;
      dm_len_o     <= '0;
      frame_done_o <= 1'b0;
      underflow_o  <= 1'b0;
    end else begin
      frame_done_o <= 1'b0;
      underflow_o  <= 1'b0;
      if (!run_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_ok) begin
            lay_q    <= layout_i;
            frames_q <= '0;
            total_q  <= '0;
            first_q  <= 1'b1;
            state_q  <= ST_RD_CTL;
          end
          ST_RD_CTL: if (mem_ack_i) begin
            ctl_q <= mem_rdata_i;
            if (!mem_rdata_i[OWN_BIT]) begin
              underflow_o <= !first_q;
              state_q     <= ST_IDLE;
            end else begin
              if (first_q) begin
                first_ctl_q <= mem_rdata_i;
                first_pos_q <= pos_i;
              end
              state_q <= ST_RD_BUF;
            end
          end
          ST_RD_BUF: if (mem_ack_i) begin
            dm_addr_o <= mem_rdata_i;
            dm_len_o  <= count_i;
            if (count_i != '0)          state_q <= ST_MOVE;
            else if (!ctl_q[STP_BIT])   state_q <= ST_WB_MID;
            else                        state_q <= ST_ADV;
          end
          ST_MOVE: if (dm_ack_i) begin
            total_q <= total_q + TOT_W'(dm_len_o);
            state_q <= ctl_q[STP_BIT] ? ST_ADV : ST_WB_MID;
          end
          ST_WB_MID: if (mem_ack_i) state_q <= ST_ADV;
          ST_ADV: begin
            if (ctl_q[ENP_BIT]) state_q <= ST_WB_FIRST;
            else begin
              first_q <= 1'b0;
              state_q <= ST_RD_CTL;
            end
          end
          ST_WB_FIRST: if (mem_ack_i) begin
            frame_done_o <= 1'b1;
            frames_q     <= frames_q + 1'b1;
            total_q      <= '0;
            first_q      <= 1'b1;
            state_q      <= (frames_q + 1'b1 >= FR_W'(MAX_FRAMES)) ? ST_IDLE : ST_RD_CTL;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    pos_sel  = (state_q == ST_WB_FIRST) ? first_pos_q : pos_i;
    word_off = (state_q == ST_RD_BUF) ? ((lay_q == LAY_SWAP) ? WA_W'(2) : WA_W'(0)) : WA_W'(1);
  end

  assign adv_o       = (state_q == ST_ADV);
  assign field_o     = ctl_q[LEN_W-1:0];
  assign total_o     = total_q;
  assign mem_req_o   = (state_q == ST_RD_CTL) || (state_q == ST_RD_BUF) ||
                       (state_q == ST_WB_MID) || (state_q == ST_WB_FIRST);
  assign mem_we_o    = (state_q == ST_WB_MID) || (state_q == ST_WB_FIRST);
  assign mem_addr_o  = base_i[ADDR_W-1:2] + WA_W'({pos_sel, 2'b00}) + word_off;
  assign mem_wdata_o = ((state_q == ST_WB_FIRST) ? first_ctl_q : ctl_q) & ~(32'd1 << OWN_BIT);
  assign dm_req_o    = (state_q == ST_MOVE);

  assert_idle_when_stopped_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!mem_req_o && !dm_req_o));
  assert_mem_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && run_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  assert_dm_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dm_req_o && !dm_ack_i && run_i) |=> (dm_req_o && $stable(dm_addr_o) && $stable(dm_len_o)));
  assert_dm_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_req_o |-> (dm_len_o != '0));
  assert_pulse_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_done_o && underflow_o));
  assert_total_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total_q <= TOT_W'(MAX_FRAME));
  assert_frame_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frames_q <= FR_W'(MAX_FRAMES));
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int RING_MAX    = 512,
  parameter int MAX_FRAME   = 2048,
  parameter int MAX_FRAMES  = 16,
  parameter int POLL_CYCLES = 4096,
  localparam int POS_W      = $clog2(RING_MAX),
  localparam int TOT_W      = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              demand_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic [POS_W:0]    ring_len_i,
  input  logic [1:0]        layout_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-3:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              dm_req_o,
  output logic [31:0]       dm_addr_o,
  output logic [LEN_W-1:0]  dm_len_o,
  input  logic              dm_ack_i,
  output logic              frame_done_o,
  output logic              underflow_o
);
  logic [POS_W-1:0] pos;
  logic             adv;
  logic [LEN_W-1:0] field, count;
  logic [TOT_W-1:0] total;

  txw_ring_ptr #(.POS_W(POS_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(!run_i), .adv_i(adv),
    .ring_len_i(ring_len_i), .pos_o(pos)
  );

  txw_len_calc #(.LEN_W(LEN_W), .TOT_W(TOT_W), .MAX_FRAME(MAX_FRAME)) u_len (
    .field_i(field), .total_i(total), .count_o(count)
  );

  txw_ctrl #(
    .ADDR_W(ADDR_W), .POS_W(POS_W), .TOT_W(TOT_W), .MAX_FRAME(MAX_FRAME),
    .MAX_FRAMES(MAX_FRAMES), .POLL_CYCLES(POLL_CYCLES)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .demand_i(demand_i),
    .base_i(ring_base_i), .layout_i(layout_i), .pos_i(pos), .adv_o(adv),
    .count_i(count), .field_o(field), .total_o(total),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .dm_req_o(dm_req_o), .dm_addr_o(dm_addr_o), .dm_len_o(dm_len_o), .dm_ack_i(dm_ack_i),
    .frame_done_o(frame_done_o), .underflow_o(underflow_o)
  );
endmodule

// File: tb/txring_walker_bench.sv
module txring_walker_bench;
  localparam int POLL = 5000;
  localparam int BW   = 'h100;   // ring base word address (byte 0x400)

  logic clk = 0, rst_n = 0, run = 0, demand = 0;
  logic [31:0] base = 32'h400;
  logic [9:0]  rlen = 10'd8;
  logic [1:0]  lay  = 2'd2;
  logic        mem_req, mem_we, mem_ack = 0, dm_req, dm_ack = 0, done, uf;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0, dm_addr;
  logic [11:0] dm_len;

  always #4 clk = ~clk;

  txring_walker #(.POLL_CYCLES(POLL)) u_txring_walker (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .demand_i(demand),
    .ring_base_i(base), .ring_len_i(rlen), .layout_i(lay),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .dm_req_o(dm_req), .dm_addr_o(dm_addr), .dm_len_o(dm_len), .dm_ack_i(dm_ack),
    .frame_done_o(done), .underflow_o(uf)
  );

  logic [31:0] mem [0:1023];
  logic [29:0] wr_log [0:63];
  logic [31:0] dma_log [0:63];
  logic [11:0] dml_log [0:63];
  int rd_n, wr_n, dm_n, done_n, uf_n;
  logic [29:0] first_rd, last_rd;
  int total = 0, bad = 0;

  // memory and data mover responders, acting on the falling edge
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[9:0]] = mem_wdata;
        if (wr_n < 64) wr_log[wr_n] = mem_addr;
        wr_n++;
      end else begin
        mem_rdata = mem[mem_addr[9:0]];
        if (rd_n == 0) first_rd = mem_addr;
        last_rd = mem_addr;
        rd_n++;
      end
      mem_ack = 1'b1;
    end
    if (dm_ack) dm_ack = 1'b0;
    else if (dm_req) begin
      if (dm_n < 64) begin dma_log[dm_n] = dm_addr; dml_log[dm_n] = dm_len; end
      dm_n++;
      dm_ack = 1'b1;
    end
    if (done) done_n++;
    if (uf) uf_n++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [31:0] ctl(bit own, bit fcs, bit stp, bit enp, int len);
    logic [11:0] f;
    f = 12'(-len);
    return {own, 1'b0, fcs, 3'b0, stp, enp, 12'h0, f};
  endfunction

  // expected count after the frame cap, from the requirement
  function automatic int cut(int len, int sofar);
    int room;
    room = 2048 - sofar;
    return (len % 4096 > room) ? room : len % 4096;
  endfunction

  task automatic put(int pos, logic [1:0] l, bit own, bit fcs, bit stp, bit enp, int len, logic [31:0] ba);
    int w;
    w = BW + pos * 4;
    mem[w+1] = ctl(own, fcs, stp, enp, len);
    if (l == 2'd3) begin mem[w+2] = ba; mem[w] = 32'hBAD0_0000 | pos; end
    else           begin mem[w] = ba;   mem[w+2] = 32'hBAD1_0000 | pos; end
    mem[w+3] = '0;
  endtask

  task automatic prep(input logic [9:0] rl, input logic [1:0] l);
    run = 0;
    cyc(3);
    for (int i = 0; i < 96; i++) mem[BW+i] = '0;
    rlen = rl; lay = l; base = 32'h400;
    rd_n = 0; wr_n = 0; dm_n = 0; done_n = 0; uf_n = 0;
    first_rd = '0; last_rd = '0;
  endtask

  task automatic go(input int wait_n);
    run = 1;
    cyc(1);
    demand = 1;
    cyc(1);
    demand = 0;
    cyc(wait_n);
  endtask

  initial begin
    #(8 * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens[3];
    int nb, sofar, e, ex_n;
    logic [1:0] l;
    bit fcs;
    void'($urandom(32'd2417));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    cyc(3);
    chk(!mem_req && !dm_req && !done && !uf, "reset", {mem_req, dm_req, done, uf}, 0);
    rst_n = 1;
    cyc(2);

    // R2 R3 R6: single buffer, standard layout
    prep(8, 2);
    put(0, 2, 1, 1, 1, 1, 64, 32'h8000);
    go(400);
    chk(dm_n == 1, "R4 req count", dm_n, 1);
    chk(dma_log[0] == 32'h8000, "R2 buffer word 0", dma_log[0], 32'h8000);
    chk(dml_log[0] == 12'd64, "R3 byte count", dml_log[0], 64);
    chk(done_n == 1 && uf_n == 0, "R6 done", done_n, 1);
    chk(mem[BW+1] == ctl(0, 1, 1, 1, 64), "R6 first writeback", mem[BW+1], ctl(0, 1, 1, 1, 64));
    chk(rd_n == 3 && wr_n == 1, "R2 access count", rd_n * 16 + wr_n, 3 * 16 + 1);

    // R8 R5 R2: position restarts after stop; chain with swapped layout
    prep(8, 3);
    put(0, 3, 1, 0, 1, 0, 100, 32'h9000);
    put(1, 3, 1, 0, 0, 0, 200, 32'h9100);
    put(2, 3, 1, 1, 0, 1, 300, 32'h9200);
    go(400);
    chk(first_rd == 30'(BW + 1), "R8 restart at 0", first_rd, BW + 1);
    chk(dm_n == 3 && dma_log[1] == 32'h9100 && dma_log[2] == 32'h9200, "R2 swapped layout", dma_log[2], 32'h9200);
    chk(dml_log[1] == 12'd200 && dml_log[2] == 12'd300, "R4 chained counts", dml_log[2], 300);
    chk(wr_n == 3 && wr_log[0] == 30'(BW + 5) && wr_log[1] == 30'(BW + 9) && wr_log[2] == 30'(BW + 1),
        "R5 writeback order", wr_log[2], BW + 1);
    chk(mem[BW+5][31] == 0 && mem[BW+9][31] == 0 && mem[BW+1][31] == 0, "R5 own cleared", mem[BW+5], 0);
    chk(done_n == 1, "R6 chain done", done_n, 1);

    // R7 underflow
    prep(8, 2);
    put(0, 2, 1, 0, 1, 0, 50, 32'hA000);
    put(1, 2, 0, 0, 0, 1, 50, 32'hA100);
    go(400);
    chk(uf_n == 1, "R7 underflow pulse", uf_n, 1);
    chk(done_n == 0, "R7 no done", done_n, 0);
    chk(mem[BW+1][31] == 1, "R7 first kept", mem[BW+1][31], 1);
    chk(dm_n == 1 && wr_n == 0, "R7 partial", dm_n, 1);

    // R10 frame cap
    prep(8, 2);
    put(0, 2, 1, 0, 1, 0, 1500, 32'hB000);
    put(1, 2, 1, 0, 0, 1, 1000, 32'hB100);
    go(400);
    chk(dm_n == 2 && dml_log[1] == 12'd548, "R10 cut", dml_log[1], 548);
    prep(8, 2);
    put(0, 2, 1, 0, 1, 0, 2048, 32'hB200);
    put(1, 2, 1, 0, 0, 1, 10, 32'hB300);
    go(400);
    chk(dm_n == 1 && dml_log[0] == 12'd2048 && done_n == 1, "R10 skip", dm_n, 1);

    // R3 zero count skipped
    prep(8, 2);
    put(0, 2, 1, 0, 1, 0, 0, 32'hC000);
    put(1, 2, 1, 0, 0, 1, 40, 32'hC100);
    go(400);
    chk(dm_n == 1 && dma_log[0] == 32'hC100 && dml_log[0] == 12'd40, "R3 zero skip", dma_log[0], 32'hC100);

    // R1 gating
    prep(8, 2);
    put(0, 2, 1, 0, 1, 1, 64, 32'hD000);
    demand = 1; cyc(1); demand = 0; cyc(100);
    chk(rd_n == 0, "R1 run low", rd_n, 0);
    base = 32'h0;
    go(200);
    chk(rd_n == 0, "R1 base zero", rd_n, 0);
    run = 0; cyc(2); base = 32'h400; lay = 2'd1;
    go(200);
    chk(rd_n == 0 && done_n == 0, "R1 bad layout", rd_n, 0);

    // R9 R8: frame limit and ring wrap
    prep(20, 2);
    for (int p = 0; p < 20; p++) put(p, 2, 1, 0, 1, 1, 10 + p, 32'hE000 + p);
    go(1000);
    chk(done_n == 16, "R9 per-scan limit", done_n, 16);
    demand = 1; cyc(1); demand = 0; cyc(600);
    chk(done_n == 20, "R9 second scan", done_n, 20);
    chk(last_rd == 30'(BW + 1), "R8 wrap to 0", last_rd, BW + 1);

    // R11 trigger during scan
    prep(8, 2);
    put(0, 2, 1, 0, 1, 1, 64, 32'hF000);
    run = 1; cyc(1);
    demand = 1; cyc(1); demand = 0; cyc(3);
    demand = 1; cyc(1); demand = 0; cyc(400);
    chk(rd_n == 4 && done_n == 1, "R11 retrigger", rd_n, 4);

    // R11 poll start
    prep(8, 2);
    put(0, 2, 1, 0, 1, 1, 64, 32'hF100);
    run = 1;
    cyc(POLL - 50);
    chk(rd_n == 0, "R11 poll early", rd_n, 0);
    cyc(300);
    chk(done_n == 1, "R11 poll start", done_n, 1);

    // random frames
    for (int it = 0; it < 30; it++) begin
      l = ($urandom % 2) ? 2'd3 : 2'd2;
      nb = 1 + $urandom % 3;
      fcs = $urandom % 2;
      prep(8, l);
      for (int b = 0; b < nb; b++) begin
        lens[b] = $urandom % 1800;
        put(b, l, 1, fcs, b == 0, b == nb - 1, lens[b], 32'h1_0000 * (it + 1) + b * 32'h100);
      end
      go(500);
      sofar = 0; ex_n = 0;
      for (int b = 0; b < nb; b++) begin
        e = cut(lens[b], sofar);
        if (e != 0) begin
          chk(dml_log[ex_n] == 12'(e) && dma_log[ex_n] == 32'h1_0000 * (it + 1) + b * 32'h100,
              "R4 random request", dml_log[ex_n], e);
          ex_n++;
        end
        sofar += e;
        chk(mem[BW + b * 4 + 1] == ctl(0, fcs, b == 0, b == nb - 1, lens[b]), "R5 random writeback",
            mem[BW + b * 4 + 1], ctl(0, fcs, b == 0, b == nb - 1, lens[b]));
      end
      chk(dm_n == ex_n, "R10 random count", dm_n, ex_n);
      chk(done_n == 1 && uf_n == 0, "R6 random done", done_n, 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule